// File: doc/BRIEF.md
# Link Training Sequence Engine

This block produces and recognizes the training pattern of a 19-lane double-data-rate data bus. Each bus phase carries sixteen data lanes, a control lane, a parity lane and a protocol lane. A phase-enable input marks every sampling instant: each clock edge of the double-rate link appears here as one enabled cycle. Pattern lengths are therefore counted in phases.

On the transmit side, a start request launches a sequence. In packet-interface mode the sequence opens with one idle control word, whose low nibble and parity lane come from input ports. It then sends a programmable number of pattern pairs. Each pair is ten phases of a "high" word followed by ten phases of its bitwise inverse. In cell-interface mode the idle word is left out. On the receive side, the block watches the incoming phases and emits a one-cycle pulse once the start of training has been recognized. A deskew stage outside this block acts on that pulse. The pulse is suppressed while an ignore bit is set.

Top module: `ltrain_engine`

## Requirements
- R1: Only cycles with `phase_en`=1 count as phases. In any cycle with `phase_en`=0 the transmit lanes, `tx_valid` and `busy` hold their values, and `start` is not taken.
- R2: With `cfg_spi_mode`=1, the first transmitted phase is the idle word: prot=0, par=`idle_par`, ctl=1, data={12'h000, `idle_nibble`}. With `cfg_spi_mode`=0 this phase is omitted.
- R3: The first half of each pair lasts 10 phases with prot=0, par=1, ctl=1, data=16'h0FFF.
- R4: The second half lasts 10 phases with prot=1, par=0, ctl=0, data=16'hF000. This is the exact bitwise inverse of the first half.
- R5: The pair is sent `cfg_reps` times. Mode, repetition count, nibble and parity are captured when the start is accepted. After the last phase, `tx_valid` is 0 and all transmit lanes are 0.
- R6: With `cfg_reps`=0, packet mode sends only the idle word. Cell mode sends nothing, and `busy` stays low.
- R7: `busy` and `tx_valid` are high from the first transmitted phase through the last one. A `start` given while busy is ignored and does not disturb the running sequence.
- R8: `rx_seen` pulses for exactly one cycle after the third consecutive enabled phase with rx ctl=1 and rx data=16'h0FFF. The protocol and parity lanes play no part in this.
- R9: A non-matching phase restarts the count of three. While `cfg_ignore`=1 no pulse is produced and the count is cleared. A run that continues past three matching phases gives no further pulse.
- R10: While reset is asserted, `busy`, `tx_valid`, all transmit lanes and `rx_seen` are 0. The asynchronous reset is released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_en | input | 1 | Marks a cycle that is one bus phase |
| start | input | 1 | Request to send a training sequence |
| cfg_spi_mode | input | 1 | 1: lead with idle word, 0: no idle word |
| cfg_reps | input | 8 | Number of pattern pairs (alpha) |
| cfg_ignore | input | 1 | 1 disables training recognition |
| idle_nibble | input | 4 | Low data nibble of the idle word |
| idle_par | input | 1 | Parity lane value of the idle word |
| tx_prot | output | 1 | Transmit protocol lane |
| tx_par | output | 1 | Transmit parity lane |
| tx_ctl | output | 1 | Transmit control lane |
| tx_data | output | 16 | Transmit data lanes |
| tx_valid | output | 1 | A training phase is on the transmit lanes |
| busy | output | 1 | Sequence in progress |
| rx_prot | input | 1 | Receive protocol lane (not used for detection) |
| rx_par | input | 1 | Receive parity lane (not used for detection) |
| rx_ctl | input | 1 | Receive control lane |
| rx_data | input | 16 | Receive data lanes |
| rx_seen | output | 1 | One-cycle pulse: training start recognized |

## Verification
The assertions check the following on every cycle:
- the transmit side freezes on disabled phases;
- the idle word lasts a single phase;
- the half-pattern boundary flips every lane;
- a recognition pulse is never repeated and never appears while ignore was set;
- every pulse follows a phase that had control high and the high data word.

Only the bench's scenarios can show the rest. This covers the exact phase count for each mode and repetition value, the idle-word contents, that a mid-sequence start is ignored, and that prot/par changes and broken runs steer the three-phase detector correctly.

// File: rtl/ltrain_pkg.sv
package ltrain_pkg;
  localparam int DATA_W   = 16;
  localparam int NIB_W    = 4;
  localparam int HALF_LEN = 10;
  localparam int PAIR_LEN = 2 * HALF_LEN;
  localparam int PH_W     = $clog2(PAIR_LEN);
  localparam int RUN_LEN  = 3;
  localparam int RUN_W    = $clog2(RUN_LEN + 1);
  localparam logic [DATA_W-1:0] HI_DATA = {{(DATA_W-12){1'b0}}, 12'hFFF};

  typedef struct packed {
    logic              prot;
    logic              par;
    logic              ctl;
    logic [DATA_W-1:0] data;
  } lane_t;

  localparam lane_t HI_WORD = '{prot: 1'b0, par: 1'b1, ctl: 1'b1, data: HI_DATA};

  typedef enum logic [1:0] {TX_IDLE, TX_LEAD, TX_PAT} tx_st_e;
endpackage

// File: rtl/ltrain_rst_sync.sv
module ltrain_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ltrain_tx_seq.sv
module ltrain_tx_seq
  import ltrain_pkg::*;
#(
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_en,
  input  logic             start,
  input  logic             cfg_spi_mode,
  input  logic [REP_W-1:0] cfg_reps,
  input  logic [NIB_W-1:0] idle_nibble,
  input  logic             idle_par,
  output tx_st_e           st,
  output logic [PH_W-1:0]  ph,
  output logic [NIB_W-1:0] nib,
  output logic             lead_par
);
  tx_st_e           st_q, st_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic [REP_W-1:0] reps_q, reps_d;
  logic [NIB_W-1:0] nib_q, nib_d;
  logic             par_q, par_d;
  logic             last_rep;

  assign last_rep = ({1'b0, rep_q} + 1'b1) == {1'b0, reps_q};

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    rep_d  = rep_q;
    reps_d = reps_q;
    nib_d  = nib_q;
    par_d  = par_q;
    if (phase_en) begin
      unique case (st_q)
        TX_IDLE: begin
          if (start) begin
            reps_d = cfg_reps;
            nib_d  = idle_nibble;
            par_d  = idle_par;
            ph_d   = '0;
            rep_d  = '0;
            if (cfg_spi_mode)        st_d = TX_LEAD;
            else if (cfg_reps != '0) st_d = TX_PAT;
          end
        end
        TX_LEAD: begin
          ph_d  = '0;
          rep_d = '0;
          st_d  = (reps_q == '0) ? TX_IDLE : TX_PAT;
        end
        TX_PAT: begin
          if (ph_q == PH_W'(PAIR_LEN - 1)) begin
            ph_d = '0;
            if (last_rep) st_d = TX_IDLE;
            else          rep_d = rep_q + 1'b1;
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      ph_q   <= '0;
      rep_q  <= '0;
      reps_q <= '0;
      nib_q  <= '0;
      par_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      rep_q  <= rep_d;
      reps_q <= reps_d;
      nib_q  <= nib_d;
      par_q  <= par_d;
    end
  end

  assign st       = st_q;
  assign ph       = ph_q;
  assign nib      = nib_q;
  assign lead_par = par_q;

  // The idle word occupies exactly one phase
  assert_lead_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_LEAD && phase_en) |=> (st_q != TX_LEAD));
endmodule

// File: rtl/ltrain_pat_gen.sv
module ltrain_pat_gen
  import ltrain_pkg::*;
(
  input  tx_st_e           st,
  input  logic [PH_W-1:0]  ph,
  input  logic [NIB_W-1:0] nib,
  input  logic             lead_par,
  output lane_t            lanes,
  output logic             valid
);
  always_comb begin
    unique case (st)
      TX_LEAD: begin
        lanes.prot = 1'b0;
        lanes.par  = lead_par;
        lanes.ctl  = 1'b1;
        lanes.data = {{(DATA_W-NIB_W){1'b0}}, nib};
      end
      TX_PAT:  lanes = (ph < PH_W'(HALF_LEN)) ? HI_WORD : ~HI_WORD;
      default: lanes = '0;
    endcase
    valid = (st != TX_IDLE);
  end
endmodule

// File: rtl/ltrain_rx_detect.sv
module ltrain_rx_detect
  import ltrain_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_en,
  input  logic              cfg_ignore,
  input  logic              rx_ctl,
  input  logic [DATA_W-1:0] rx_data,
  output logic              seen
);
  logic [RUN_W-1:0] run_q, run_d;
  logic             seen_q, seen_d;
  logic             hit;

  assign hit = rx_ctl && (rx_data == HI_DATA);

  always_comb begin
    run_d  = run_q;
    seen_d = 1'b0;
    if (phase_en) begin
      if (cfg_ignore) begin
        run_d = '0;
      end else if (hit) begin
        if (run_q != RUN_W'(RUN_LEN)) run_d = run_q + 1'b1;
        seen_d = (run_q == RUN_W'(RUN_LEN - 1));
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      seen_q <= seen_d;
    end
  end

  assign seen = seen_q;

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> !seen_q);
  assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ignore |=> !seen_q);
  assert_pulse_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seen_q) |-> ($past(rx_ctl) && $past(rx_data) == HI_DATA && $past(phase_en)));
endmodule

// File: rtl/ltrain_engine.sv
module ltrain_engine
  import ltrain_pkg::*;
#(
  parameter int REP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_en,
  input  logic              start,
  input  logic              cfg_spi_mode,
  input  logic [REP_W-1:0]  cfg_reps,
  input  logic              cfg_ignore,
  input  logic [NIB_W-1:0]  idle_nibble,
  input  logic              idle_par,
  output logic              tx_prot,
  output logic              tx_par,
  output logic              tx_ctl,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              busy,
  input  logic              rx_prot,
  input  logic              rx_par,
  input  logic              rx_ctl,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_seen
);
  logic             rst_int_n;
  tx_st_e           st;
  logic [PH_W-1:0]  ph;
  logic [NIB_W-1:0] nib;
  logic             lead_par;
  lane_t            lanes;
  logic             valid;
  lane_t            rx_lanes;

  ltrain_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  ltrain_tx_seq #(.REP_W(REP_W)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .phase_en(phase_en), .start(start),
    .cfg_spi_mode(cfg_spi_mode), .cfg_reps(cfg_reps),
    .idle_nibble(idle_nibble), .idle_par(idle_par),
    .st(st), .ph(ph), .nib(nib), .lead_par(lead_par)
  );

  ltrain_pat_gen u_gen (
    .st(st), .ph(ph), .nib(nib), .lead_par(lead_par),
    .lanes(lanes), .valid(valid)
  );

  // Protocol and parity lanes are carried in the bundle but the detector uses only ctl/data
  assign rx_lanes = '{prot: rx_prot, par: rx_par, ctl: rx_ctl, data: rx_data};

  ltrain_rx_detect u_rx (
    .clk(clk), .rst_n(rst_int_n), .phase_en(phase_en), .cfg_ignore(cfg_ignore),
    .rx_ctl(rx_lanes.ctl), .rx_data(rx_lanes.data), .seen(rx_seen)
  );

  assign tx_prot  = lanes.prot;
  assign tx_par   = lanes.par;
  assign tx_ctl   = lanes.ctl;
  assign tx_data  = lanes.data;
  assign tx_valid = valid;
  assign busy     = valid;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !phase_en |=> ($stable(lanes) && $stable(busy)));
  assert_half_flip_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st == TX_PAT && phase_en && ph == PH_W'(HALF_LEN - 1)) |=> (lanes == ~$past(lanes)));

  logic unused_rx;
  assign unused_rx = rx_lanes.prot ^ rx_lanes.par;
endmodule

// File: tb/ltrain_engine_tb.sv
module ltrain_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_en = 1'b0;
  logic        start = 1'b0;
  logic        cfg_spi_mode = 1'b0;
  logic [7:0]  cfg_reps = '0;
  logic        cfg_ignore = 1'b0;
  logic [3:0]  idle_nibble = '0;
  logic        idle_par = 1'b0;
  logic        rx_prot = 1'b0, rx_par = 1'b0, rx_ctl = 1'b0;
  logic [15:0] rx_data = '0;
  logic        tx_prot, tx_par, tx_ctl, tx_valid, busy, rx_seen;
  logic [15:0] tx_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  ltrain_engine u_dut (
    .clk(clk), .rst_n(rst_n), .phase_en(phase_en), .start(start),
    .cfg_spi_mode(cfg_spi_mode), .cfg_reps(cfg_reps), .cfg_ignore(cfg_ignore),
    .idle_nibble(idle_nibble), .idle_par(idle_par),
    .tx_prot(tx_prot), .tx_par(tx_par), .tx_ctl(tx_ctl), .tx_data(tx_data),
    .tx_valid(tx_valid), .busy(busy),
    .rx_prot(rx_prot), .rx_par(rx_par), .rx_ctl(rx_ctl), .rx_data(rx_data),
    .rx_seen(rx_seen)
  );

  // Receive vectors: {ignore, ctl, data[15:0], prot, par, expected pulse}
  localparam int NRX = 20;
  localparam logic [20:0] RXV [NRX] = '{
    {1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0FFF, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h0FFF, 1'b1, 1'b1, 1'b1},   // R8 third match, prot/par varied
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b0, 1'b0},   // R9 no repeat on longer run
    {1'b0, 1'b0, 16'hF000, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0FFE, 1'b0, 1'b1, 1'b0},   // R9 data mismatch restarts
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b0, 16'h0FFF, 1'b0, 1'b1, 1'b0},   // R9 ctl low restarts
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b1},
    {1'b0, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},   // R9 ignore set
    {1'b1, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    {1'b1, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 16'h0FFF, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] exp_lane(input bit spi, input logic [3:0] nib,
                                           input bit par, input int i);
    int p, q;
    if (spi && i == 0) return {1'b0, par, 1'b1, 12'h000, nib};
    p = spi ? i - 1 : i;
    q = p % 20;
    if (q < 10) return {1'b0, 1'b1, 1'b1, 16'h0FFF};
    return {1'b1, 1'b0, 1'b0, 16'hF000};
  endfunction

  function automatic logic [20:0] tx_now();
    return {busy, tx_valid, tx_prot, tx_par, tx_ctl, tx_data};
  endfunction

  task automatic run_tx(input bit spi, input logic [7:0] reps, input logic [3:0] nib,
                        input bit par, input bit restart, input bit gap);
    int n;
    n = (spi ? 1 : 0) + 20 * int'(reps);
    @(negedge clk);
    cfg_spi_mode = spi; cfg_reps = reps; idle_nibble = nib; idle_par = par;
    start = 1'b1; phase_en = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (spi && i == 0)
        check("R2 idle word", tx_now(), {2'b11, exp_lane(spi, nib, par, i)});
      else if (((spi ? i - 1 : i) % 20) < 10)
        check("R3 high half", tx_now(), {2'b11, exp_lane(spi, nib, par, i)});
      else
        check("R4 inverse half", tx_now(), {2'b11, exp_lane(spi, nib, par, i)});
      if (restart && i == 5) begin
        start = 1'b1; cfg_spi_mode = ~spi; cfg_reps = 8'd7; idle_nibble = ~nib;
      end else begin
        start = 1'b0;
      end
      if (gap && i == 7) begin
        phase_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
          @(posedge clk); @(negedge clk);
          check("R1 hold without phase", tx_now(), {2'b11, exp_lane(spi, nib, par, i)});
        end
        phase_en = 1'b1;
      end
      @(posedge clk); @(negedge clk);
    end
    start = 1'b0;
    if (reps == 0)
      check("R6 zero repetitions", tx_now(), 21'h0);
    else
      check(restart ? "R7 end after restart attempt" : "R5 end of sequence", tx_now(), 21'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {tx_now()[20:1], rx_seen}, 21'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release", {tx_now()[20:1], rx_seen}, 21'h0);

    // Receive table walk, one phase per cycle
    phase_en = 1'b1;
    for (int e = 0; e < NRX; e++) begin
      {cfg_ignore, rx_ctl, rx_data, rx_prot, rx_par} = RXV[e][20:1];
      @(posedge clk); @(negedge clk);
      check(RXV[e][0] ? "R8 pulse" : "R9 no pulse", {20'h0, rx_seen}, {20'h0, RXV[e][0]});
    end
    cfg_ignore = 1'b0; rx_ctl = 1'b1; rx_data = 16'h0FFF;
    @(posedge clk); @(negedge clk);
    check("R8 pulse after ignore cleared", {20'h0, rx_seen}, 21'h1);

    // R8 gaps in phase_en do not count as phases
    rx_ctl = 1'b0; @(posedge clk); @(negedge clk);
    rx_ctl = 1'b1;
    for (int k = 0; k < 2; k++) begin @(posedge clk); @(negedge clk); end
    phase_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      check("R1 detector idle without phase", {20'h0, rx_seen}, 21'h0);
    end
    phase_en = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 third enabled match", {20'h0, rx_seen}, 21'h1);
    rx_ctl = 1'b0; rx_data = 16'h0;

    // R1 start not taken without phase
    phase_en = 1'b0; start = 1'b1; cfg_spi_mode = 1'b1; cfg_reps = 8'd1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check("R1 start needs phase", tx_now(), 21'h0);
    phase_en = 1'b1;

    run_tx(1'b1, 8'd2, 4'hA, 1'b1, 1'b1, 1'b0);
    run_tx(1'b0, 8'd1, 4'h5, 1'b0, 1'b0, 1'b1);
    run_tx(1'b1, 8'd0, 4'h3, 1'b0, 1'b0, 1'b0);
    run_tx(1'b0, 8'd0, 4'h3, 1'b1, 1'b0, 1'b0);
    run_tx(1'b0, 8'd3, 4'hC, 1'b1, 1'b1, 1'b1);
    run_tx(1'b1, 8'd1, 4'h6, 1'b0, 1'b0, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule